// File: doc/BRIEF.md
# Byte-Wide Indirect Access Bridge to a 32-Bit Register Bus

This block gives a byte-wide register port, such as one sitting behind a slow serial control link, access to a 32-bit internal register bus. The byte side sees three 4-byte staging windows and one 4-byte result window, plus one status byte. Each window holds its bytes least significant first. The staging windows hold write data, the write address and the read address. Writing the highest byte of an address window launches one 32-bit access on the internal request/acknowledge port.

A write must be set up in a fixed order. All four write-data bytes go in first, and the write address follows, because the top byte of the write address starts the transfer. A read only needs the read address. When the target acknowledges a read, its 32-bit result is captured into the result window, where the byte side can fetch it one byte at a time. Only one internal access can be outstanding at a time. A launch attempt made while an access is still pending is dropped, and a sticky error flag records it.

Top module: `byte_reg_bridge`

## Requirements
- R1: After reset `ext_req` is 0. Every staging byte, every result byte and the status byte read 0.
- R2: With the default base 0xC85, the window bytes map as follows, least significant byte at the lowest address: write data at 0xC85..0xC88, write address at 0xC89..0xC8C, read address at 0xC8D..0xC90, read result at 0xC91..0xC94. A byte written into a staging window reads back at the same address. A byte read returns data on `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` holds that value until the next read.
- R3: Writing byte 0xC8C while idle raises `ext_req` at the next clock edge, with `ext_we`=1. `ext_addr` carries the four write-address bytes, including the byte just written, and `ext_wdata` carries the staged write data.
- R4: Writes to the lower three bytes of either address window, or to the write-data window, only stage data and never raise `ext_req`.
- R5: Writing byte 0xC90 while idle raises `ext_req` with `ext_we`=0 and `ext_addr` equal to the staged read address. The `ext_rdata` value present at the acknowledge edge is then readable at 0xC91..0xC94, least significant byte first.
- R6: While `ext_req` is high and `ext_ack` is low, `ext_req`, `ext_we`, `ext_addr` and `ext_wdata` hold their values. Status byte 0xC95 bit 0 reads 1 during this time. The result window keeps its previous contents until the acknowledge arrives.
- R7: Writing either top address byte while an access is outstanding starts nothing, leaves the outstanding access unchanged, and sets status bit 1 (overrun). Bit 1 stays set after the access completes.
- R8: Writing the status byte with bit 0 set clears the overrun bit. Writing it with bit 0 clear leaves the overrun bit unchanged.
- R9: Addresses outside 0xC85..0xC95 read as 0, and writes to them change no window and no status bit.
- R10: `ext_req` drops at the clock edge that samples `ext_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address on the byte side |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Byte read data, registered |
| ext_req | output | 1 | Internal access request, held until acknowledged |
| ext_we | output | 1 | 1 for an internal write, 0 for a read |
| ext_addr | output | 32 | Internal access address |
| ext_wdata | output | 32 | Internal write data |
| ext_ack | input | 1 | Internal access acknowledge |
| ext_rdata | input | 32 | Internal read data, valid with `ext_ack` |

## Verification
The random part of the bench writes staging bytes in a rotated lane order, so that a lane swap or a wrong byte position shows up as a mismatch in the assembled address or data word. It also draws acknowledge latencies from zero to several cycles, which separates a design that holds its request from one that drops it, or that latches a result before the acknowledge arrives. Directed cases cover the following:
- a top-byte write made during a long pending access, which shows whether the overrun path or a second launch wins;
- status writes with bit 0 clear and with bit 0 set, which show whether the flag is really sticky;
- stray writes just outside the window range, which expose decode edges that are off by one.

// File: rtl/bridge_pkg.sv
// Shared constants and types for the byte-wide indirect access bridge.
// Assumes four-byte windows and a 32-bit internal word.
package bridge_pkg;
    localparam int WIN_BYTES = 4;
    localparam int LANE_W    = $clog2(WIN_BYTES);
    localparam int WORD_W    = 8 * WIN_BYTES;

    // Window kinds, in the address order the decoder relies on
    typedef enum logic [2:0] {
        WIN_WDATA = 3'd0,
        WIN_WADDR = 3'd1,
        WIN_RADDR = 3'd2,
        WIN_RDATA = 3'd3,
        WIN_STAT  = 3'd4,
        WIN_NONE  = 3'd5
    } win_e;

    typedef struct packed {
        win_e              win;
        logic [LANE_W-1:0] lane;
    } sel_t;
endpackage

// File: rtl/bridge_decode.sv
// Address decoder: maps a byte address to a window kind and a byte lane.
// Assumes the four windows are contiguous from BASE, with the status byte right after them.
module bridge_decode
    import bridge_pkg::*;
#(
    parameter int             AW   = 12,
    parameter logic [AW-1:0]  BASE = 12'hC85
) (
    input  logic [AW-1:0] addr,
    output sel_t          sel
);
    localparam logic [AW-1:0] SPAN = AW'(4 * WIN_BYTES);

    logic [AW-1:0] off;

    // Offset from base, then split into window index and lane
    always_comb begin
        off = addr - BASE;
        sel.lane = off[LANE_W-1:0];
        if (off < SPAN)
            sel.win = win_e'({1'b0, off[LANE_W+1:LANE_W]});
        else if (off == SPAN)
            sel.win = WIN_STAT;
        else
            sel.win = WIN_NONE;
    end
endmodule

// File: rtl/bridge_stage.sv
// Staging registers for write data, write address and read address.
// Also produces the launch pulses when the top lane of an address window is written.
// Exports each address window's next value, so a launch includes the byte written that cycle.
module bridge_stage
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_t              sel,
    input  logic [7:0]        wbyte,
    output logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] waddr_q,
    output logic [WORD_W-1:0] raddr_q,
    output logic [WORD_W-1:0] waddr_d,
    output logic [WORD_W-1:0] raddr_d,
    output logic              fire_wr,
    output logic              fire_rd
);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(WIN_BYTES - 1);

    logic [WORD_W-1:0] wdata_d;

    for (genvar l = 0; l < WIN_BYTES; l++) begin : g_lane
        logic hit;
        assign hit = wr_en && (sel.lane == LANE_W'(l));
        // Next value of each lane: replaced when addressed, else held
        assign wdata_d[l*8 +: 8] = (hit && sel.win == WIN_WDATA) ? wbyte : wdata_q[l*8 +: 8];
        assign waddr_d[l*8 +: 8] = (hit && sel.win == WIN_WADDR) ? wbyte : waddr_q[l*8 +: 8];
        assign raddr_d[l*8 +: 8] = (hit && sel.win == WIN_RADDR) ? wbyte : raddr_q[l*8 +: 8];
    end

    // Launch pulses on a write to the top lane of an address window
    assign fire_wr = wr_en && sel.win == WIN_WADDR && sel.lane == TOP_LANE;
    assign fire_rd = wr_en && sel.win == WIN_RADDR && sel.lane == TOP_LANE;

    // Staging storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            waddr_q <= '0;
            raddr_q <= '0;
        end else begin
            wdata_q <= wdata_d;
            waddr_q <= waddr_d;
            raddr_q <= raddr_d;
        end
    end
endmodule

// File: rtl/bridge_xfer.sv
// Internal access engine: a request/acknowledge handshake with one access outstanding.
// Snapshots the address and data at launch, captures the read result on acknowledge,
// and keeps the sticky overrun flag. Assumes ext_ack is only meaningful while ext_req is high.
module bridge_xfer
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_wr,
    input  logic              fire_rd,
    input  logic              stat_clr,
    input  logic [WORD_W-1:0] waddr_d,
    input  logic [WORD_W-1:0] raddr_d,
    input  logic [WORD_W-1:0] wdata_q,
    input  logic              ext_ack,
    input  logic [WORD_W-1:0] ext_rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [WORD_W-1:0] ext_addr,
    output logic [WORD_W-1:0] ext_wdata,
    output logic [WORD_W-1:0] rd_q,
    output logic              ovr_q
);
    logic launch;
    assign launch = fire_wr || fire_rd;

    // Handshake: launch when idle, drop the request on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_req   <= 1'b0;
            ext_we    <= 1'b0;
            ext_addr  <= '0;
            ext_wdata <= '0;
        end else if (ext_req) begin
            if (ext_ack)
                ext_req <= 1'b0;
        end else if (launch) begin
            ext_req  <= 1'b1;
            ext_we   <= fire_wr;
            ext_addr <= fire_wr ? waddr_d : raddr_d;
            if (fire_wr)
                ext_wdata <= wdata_q;
        end
    end

    // Read result capture on the acknowledge of a read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (ext_req && ext_ack && !ext_we)
            rd_q <= ext_rdata;
    end

    // Sticky overrun: set by a launch while busy, cleared by a status write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (launch && ext_req)
            ovr_q <= 1'b1;
        else if (stat_clr)
            ovr_q <= 1'b0;
    end
endmodule

// File: rtl/bridge_rdmux.sv
// Byte read-back: picks the addressed byte of a window or the status byte.
// Registers it on a read strobe and holds it otherwise. Unmapped addresses give 0.
module bridge_rdmux
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  sel_t              sel,
    input  logic [WORD_W-1:0] wdata_q,
    input  logic [WORD_W-1:0] waddr_q,
    input  logic [WORD_W-1:0] raddr_q,
    input  logic [WORD_W-1:0] rd_q,
    input  logic              busy,
    input  logic              ovr,
    output logic [7:0]        rdata
);
    logic [7:0] pick;

    // Combinational byte select
    always_comb begin
        case (sel.win)
            WIN_WDATA: pick = wdata_q[sel.lane*8 +: 8];
            WIN_WADDR: pick = waddr_q[sel.lane*8 +: 8];
            WIN_RADDR: pick = raddr_q[sel.lane*8 +: 8];
            WIN_RDATA: pick = rd_q[sel.lane*8 +: 8];
            WIN_STAT:  pick = {6'b0, ovr, busy};
            default:   pick = 8'h00;
        endcase
    end

    // Output register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= pick;
    end
endmodule

// File: rtl/byte_reg_bridge.sv
// Top level of the byte-wide indirect access bridge.
// Connects the decoder, the staging registers, the access engine and the read-back.
// Assumes the byte side never strobes bus_wr and bus_rd in the same cycle.
module byte_reg_bridge
    import bridge_pkg::*;
#(
    parameter int            AW   = 12,
    parameter logic [AW-1:0] BASE = 12'hC85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              ext_req,
    output logic              ext_we,
    output logic [WORD_W-1:0] ext_addr,
    output logic [WORD_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [WORD_W-1:0] ext_rdata
);
    sel_t              sel;
    logic [WORD_W-1:0] wdata_q, waddr_q, raddr_q, waddr_d, raddr_d, rd_q;
    logic              fire_wr, fire_rd, ovr_q, stat_clr;

    // Clear request for the overrun flag
    assign stat_clr = bus_wr && sel.win == WIN_STAT && bus_wdata[0];

    bridge_decode #(.AW(AW), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    bridge_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .sel     (sel),
        .wbyte   (bus_wdata),
        .wdata_q (wdata_q),
        .waddr_q (waddr_q),
        .raddr_q (raddr_q),
        .waddr_d (waddr_d),
        .raddr_d (raddr_d),
        .fire_wr (fire_wr),
        .fire_rd (fire_rd)
    );

    bridge_xfer u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_wr   (fire_wr),
        .fire_rd   (fire_rd),
        .stat_clr  (stat_clr),
        .waddr_d   (waddr_d),
        .raddr_d   (raddr_d),
        .wdata_q   (wdata_q),
        .ext_ack   (ext_ack),
        .ext_rdata (ext_rdata),
        .ext_req   (ext_req),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .rd_q      (rd_q),
        .ovr_q     (ovr_q)
    );

    bridge_rdmux u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .sel     (sel),
        .wdata_q (wdata_q),
        .waddr_q (waddr_q),
        .raddr_q (raddr_q),
        .rd_q    (rd_q),
        .busy    (ext_req),
        .ovr     (ovr_q),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/bridge_chk.sv
// Protocol checker for the bridge, attached to the top level with a bind.
// Assumes it sees the access engine's read-result register and overrun flag.
module bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        ext_req,
    input logic        ext_we,
    input logic        ext_ack,
    input logic [31:0] ext_addr,
    input logic [31:0] ext_wdata,
    input logic [31:0] rd_q,
    input logic        ovr_q
);
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_we) && $stable(ext_addr) && $stable(ext_wdata)));

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ack) |=> !ext_req);

    // R4
    launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_req) |-> $past(bus_wr));

    // R5
    result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_q) |-> $past(ext_req && ext_ack && !ext_we));

    // R8
    ovr_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(bus_wr));
endmodule

bind byte_reg_bridge bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_ack   (ext_ack),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .rd_q      (rd_q),
    .ovr_q     (ovr_q)
);

// File: tb/sim_byte_reg_bridge.sv
// Self-checking bench for byte_reg_bridge: directed corners plus seeded random transactions.
module sim_byte_reg_bridge;
    localparam logic [11:0] B_WD = 12'hC85;
    localparam logic [11:0] B_WA = 12'hC89;
    localparam logic [11:0] B_RA = 12'hC8D;
    localparam logic [11:0] B_RD = 12'hC91;
    localparam logic [11:0] A_ST = 12'hC95;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        ext_req, ext_we, ext_ack;
    logic [31:0] ext_addr, ext_wdata, ext_rdata;

    int nchk = 0;
    int nerr = 0;
    int ack_lat = 0;
    int ndone = 0;
    logic        log_we;
    logic [31:0] log_addr, log_wd;
    logic [31:0] m_wd, m_wa, m_ra, m_rd;
    logic        m_ovr;
    bit          reported = 0;

    always #2 clk = ~clk;

    byte_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_req(ext_req), .ext_we(ext_we),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
    );

    function automatic logic [31:0] rfun(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // Byte write; the bench's staging model follows the window layout of R2
    task automatic bw(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a >= B_WD && a < B_WA) m_wd[(a - B_WD) * 8 +: 8] = d;
        else if (a >= B_WA && a < B_RA) m_wa[(a - B_WA) * 8 +: 8] = d;
        else if (a >= B_RA && a < B_RD) m_ra[(a - B_RA) * 8 +: 8] = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] d;
        br(a, d);
        chk(req, {24'h0, d}, {24'h0, exp}, $sformatf("read @%h", a));
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        while (ext_req && g < 100) begin @(negedge clk); g++; end
        chk("R10", {31'h0, ext_req}, 32'h0, "access still pending");
    endtask

    // Full write transaction with lanes written in rotated order
    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int lat);
        int rot;
        ack_lat = lat;
        rot = $urandom % 4;
        for (int i = 0; i < 4; i++) begin
            int l;
            l = (rot + i) % 4;
            bw(B_WD + 12'(l), d[l*8 +: 8]);
        end
        for (int i = 0; i < 3; i++) begin
            int l;
            l = (rot + i) % 3;
            bw(B_WA + 12'(l), a[l*8 +: 8]);
        end
        chk("R4", {31'h0, ext_req}, 32'h0, "req after lower address bytes");
        bw(B_WA + 12'd3, a[31:24]);
        chk("R3", {31'h0, ext_req}, 32'h1, "req after top write-address byte");
        chk("R3", {31'h0, ext_we}, 32'h1, "we on write launch");
        chk("R3", ext_addr, a, "write address");
        chk("R3", ext_wdata, d, "write data");
        wait_idle();
        chk("R3", log_addr, a, "address seen by target");
        chk("R3", log_wd, d, "data seen by target");
    endtask

    // Full read transaction, then read the four result bytes back
    task automatic do_read(input logic [31:0] a, input int lat);
        ack_lat = lat;
        for (int l = 0; l < 3; l++) bw(B_RA + 12'(l), a[l*8 +: 8]);
        chk("R4", {31'h0, ext_req}, 32'h0, "req after lower read-address bytes");
        bw(B_RA + 12'd3, a[31:24]);
        chk("R5", {31'h0, ext_req}, 32'h1, "req after top read-address byte");
        chk("R5", {31'h0, ext_we}, 32'h0, "we on read launch");
        chk("R5", ext_addr, a, "read address");
        wait_idle();
        m_rd = rfun(a);
        for (int l = 0; l < 4; l++) rchk("R5", B_RD + 12'(l), m_rd[l*8 +: 8]);
    endtask

    // Target responder, acting just after each rising edge
    initial begin
        int cnt;
        bit seen;
        cnt = 0; seen = 0;
        ext_ack = 1'b0; ext_rdata = '0;
        forever begin
            @(posedge clk); #1;
            if (ext_ack) begin
                ext_ack = 1'b0;
                chk("R10", {31'h0, ext_req}, 32'h0, "req after acknowledge edge");
            end else if (ext_req && rst_n) begin
                if (!seen) begin seen = 1; cnt = ack_lat; end
                if (cnt == 0) begin
                    ext_ack = 1'b1;
                    ext_rdata = rfun(ext_addr);
                    log_we = ext_we; log_addr = ext_addr; log_wd = ext_wdata;
                    ndone++;
                    seen = 0;
                end else cnt--;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        report();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        m_wd = '0; m_wa = '0; m_ra = '0; m_rd = '0; m_ovr = 1'b0;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        chk("R1", {31'h0, ext_req}, 32'h0, "req in reset");
        rst_n = 1'b1;

        // R1: reset state
        rchk("R1", B_WD, 8'h00);
        rchk("R1", B_RA + 12'd3, 8'h00);
        rchk("R1", B_RD, 8'h00);
        rchk("R1", A_ST, 8'h00);

        // R2: staging byte placement and read-back; R4: no launch
        bw(B_WD + 12'd0, 8'h11); bw(B_WD + 12'd1, 8'h22);
        bw(B_WD + 12'd2, 8'h33); bw(B_WD + 12'd3, 8'h44);
        rchk("R2", B_WD + 12'd0, 8'h11);
        rchk("R2", B_WD + 12'd3, 8'h44);
        bw(B_WA + 12'd0, 8'hA0); bw(B_WA + 12'd1, 8'hA1); bw(B_WA + 12'd2, 8'hA2);
        chk("R4", {31'h0, ext_req}, 32'h0, "req after staging only");
        rchk("R2", B_WA + 12'd2, 8'hA2);
        br(B_WA, d);
        @(negedge clk); @(negedge clk);
        chk("R2", {24'h0, bus_rdata}, 32'hA0, "read data holds between reads");

        // R3 + R6: write launch with a slow target
        ack_lat = 4;
        bw(B_WA + 12'd3, 8'hA3);
        chk("R3", {31'h0, ext_req}, 32'h1, "req after top byte");
        chk("R3", ext_addr, 32'hA3A2A1A0, "launched address includes new top byte");
        chk("R3", ext_wdata, 32'h44332211, "launched data");
        rchk("R6", A_ST, 8'h01);
        chk("R6", ext_addr, 32'hA3A2A1A0, "address held while busy");
        wait_idle();
        chk("R3", {31'h0, log_we}, 32'h1, "target saw a write");

        // R5 + R6: read launch, result window unchanged while busy
        ack_lat = 5;
        for (int l = 0; l < 3; l++) bw(B_RA + 12'(l), 8'h10 + 8'(l));
        bw(B_RA + 12'd3, 8'h13);
        rchk("R6", B_RD, 8'h00);
        wait_idle();
        m_rd = rfun(32'h13121110);
        for (int l = 0; l < 4; l++) rchk("R5", B_RD + 12'(l), m_rd[l*8 +: 8]);

        // R7 + R8: trigger during busy, sticky flag, clear rule
        ack_lat = 8;
        bw(B_RA + 12'd3, 8'h55);
        bw(B_RA + 12'd3, 8'h66);
        chk("R7", ext_addr, 32'h55121110, "outstanding address kept");
        chk("R7", {31'h0, ext_we}, 32'h0, "outstanding kind kept");
        bw(B_WA + 12'd3, 8'h77);
        chk("R7", ext_addr, 32'h55121110, "write trigger while busy ignored");
        rchk("R7", A_ST, 8'h03);
        wait_idle();
        chk("R7", 32'(ndone), 32'd3, "only one access per launch");
        rchk("R7", A_ST, 8'h02);
        m_rd = rfun(32'h55121110);
        rchk("R7", B_RD, m_rd[7:0]);
        bw(A_ST, 8'h00);
        rchk("R8", A_ST, 8'h02);
        bw(A_ST, 8'h01);
        rchk("R8", A_ST, 8'h00);

        // R9: unmapped neighbours
        bw(12'hC84, 8'hFF);
        bw(12'hC96, 8'hFF);
        rchk("R9", 12'hC84, 8'h00);
        rchk("R9", 12'hC96, 8'h00);
        rchk("R9", B_WD, m_wd[7:0]);
        rchk("R9", B_RD + 12'd3, m_rd[31:24]);
        rchk("R9", A_ST, 8'h00);
        chk("R9", {31'h0, ext_req}, 32'h0, "no launch from unmapped writes");

        // Random transactions
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom % 3;
            if (op == 0) do_write($urandom, $urandom, $urandom % 6);
            else if (op == 1) do_read($urandom, $urandom % 6);
            else begin
                int w, l;
                w = $urandom % 3; l = $urandom % 4;
                case (w)
                    0: rchk("R2", B_WD + 12'(l), m_wd[l*8 +: 8]);
                    1: rchk("R2", B_WA + 12'(l), m_wa[l*8 +: 8]);
                    default: rchk("R2", B_RA + 12'(l), m_ra[l*8 +: 8]);
                endcase
            end
        end
        rchk("R8", A_ST, 8'h00);

        repeat (3) @(negedge clk);
        report();
    end
endmodule